// File: doc/BRIEF.md
# Burst DMA Channel Engine

This block is one channel of a DMA engine that sits between a memory bus initiator port and a coprocessor's word-stream port. Software sets a buffer base address, a byte count, a direction and a completion mode, then raises the run bit. The engine splits the buffer into fixed bursts of `BURST_BYTES` bytes. It issues each burst as a multi-flit request on a simple valid/acknowledge command and response interface, and it moves 32-bit words through an internal FIFO to or from the coprocessor.

In the read direction, memory read bursts fill a FIFO that the coprocessor drains through a valid/ready output port. In the write direction, the coprocessor fills a FIFO through a valid/ready input port, and write bursts drain it. Only one burst is in flight at a time. The engine leaves the busy state with a done bit or an error bit. In interrupt mode, the done bit also drives an interrupt line. The status and the interrupt stay asserted until software lowers the run bit.

Top module: `bdma_chan`

## Requirements
- R1: While reset is asserted and after it is released with run low, busy, done, err, irq, cmd_val, rsp_ack, tc_val and fc_rdy are all 0.
- R2: After a start, command flit n (counted from 0 across the whole transfer) carries address base + 4·n, computed over the full address width so that carries reach the high word. Each burst is BURST_BYTES/4 flits, only its last flit has cmd_eop = 1, and the address is held while cmd_ack is low.
- R3: With cfg_dir = 0 (toward the coprocessor), every flit has cmd_wr = 0 and expects BURST_BYTES/4 response flits. The response words appear on tc_data in address order.
- R4: With cfg_dir = 1 (from the coprocessor), every flit has cmd_wr = 1 and expects one response flit per burst. The flits carry the words accepted on fc_data, in arrival order.
- R5: A read burst is requested only when the FIFO has room for a whole burst. With a FIFO depth of two bursts and a stalled coprocessor, exactly two bursts are issued.
- R6: A write burst is requested only when a whole burst of words is buffered. With one word missing, no command flit appears.
- R7: After the response to the last burst, busy drops and done rises. irq equals done when cfg_irq_en = 1 and stays 0 when cfg_irq_en = 0. Both hold while run stays high and clear within two cycles after run is lowered.
- R8: A response flit with rsp_err = 1 ends the transfer after that burst's responses. err is set, no further command flit is issued, and done and irq stay 0.
- R9: A start with a base address or a byte count that is not a multiple of BURST_BYTES sets err at once and issues no command flit.
- R10: A start with a byte count of 0 sets done at once (and irq in interrupt mode) and issues no command flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_lo | input | 32 | Buffer base address, low word |
| cfg_base_hi | input | ADDR_W-32 | Buffer base address, extension bits |
| cfg_size | input | 32 | Buffer size in bytes |
| cfg_dir | input | 1 | 0: memory to coprocessor, 1: coprocessor to memory |
| cfg_irq_en | input | 1 | 1: interrupt on completion, 0: no interrupt |
| cfg_run | input | 1 | Start request; lowering it clears status |
| stat_busy | output | 1 | Transfer in progress |
| stat_done | output | 1 | Transfer completed |
| stat_err | output | 1 | Transfer stopped on error or bad configuration |
| irq | output | 1 | Completion interrupt |
| cmd_val | output | 1 | Command flit valid |
| cmd_ack | input | 1 | Command flit accepted |
| cmd_addr | output | ADDR_W | Flit byte address |
| cmd_wr | output | 1 | 1: write flit, 0: read flit |
| cmd_wdata | output | 32 | Write data |
| cmd_eop | output | 1 | Last flit of burst |
| rsp_val | input | 1 | Response flit valid |
| rsp_ack | output | 1 | Response flit accepted |
| rsp_rdata | input | 32 | Read data |
| rsp_err | input | 1 | Error on this response flit |
| tc_val | output | 1 | Word to coprocessor valid |
| tc_rdy | input | 1 | Coprocessor takes the word |
| tc_data | output | 32 | Word to coprocessor |
| fc_val | input | 1 | Word from coprocessor valid |
| fc_rdy | output | 1 | Engine takes the word |
| fc_data | input | 32 | Word from coprocessor |

## Verification
The bench goes after the address walk across burst edges and across a carry from the low word into the high word. A design that increments only 32 bits would send the second burst back to the bottom of the low space. It stalls the coprocessor on a multi-burst read and holds back one write word. A design that checks FIFO room or fill level wrongly would either overrun the FIFO with a third burst or write a partial burst full of stale data. It injects an error response in the middle of and at the start of transfers, and it starts the engine with a misaligned base, a misaligned size and a zero size. A design that got these wrong would keep bursting past a failure, set done and irq together with err, or hang in busy. Random transfers mix both directions and both modes, with random acknowledge and ready gaps, so that a flit lost or duplicated under backpressure shows up as a data mismatch.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CMD,
    ST_RSP,
    ST_END
  } bdma_st_e;
endpackage

// File: rtl/bdma_rst_sync.sv
module bdma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bdma_fifo.sv
module bdma_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, empty, do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
      if (do_push && !do_pop) cnt_d = cnt_q + CNT_W'(1);
      else if (do_pop && !do_push) cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign count = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> !full); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |-> !empty); // R6
endmodule

// File: rtl/bdma_ctrl.sv
module bdma_ctrl
  import bdma_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int BURST_BYTES = 16,
  parameter int DEPTH       = 8,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [31:0]       cfg_size,
  input  logic              cfg_dir,
  input  logic              cfg_irq_en,
  input  logic              cfg_run,
  input  logic [CNT_W-1:0]  rd_count,
  input  logic [CNT_W-1:0]  wr_count,
  output logic              cmd_val,
  input  logic              cmd_ack,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_wr,
  output logic              cmd_eop,
  input  logic              rsp_val,
  output logic              rsp_ack,
  input  logic              rsp_err,
  output logic              flush,
  output logic              rd_push,
  output logic              wr_pop,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              irq,
  output logic              dir
);
  localparam int BW     = BURST_BYTES / 4;
  localparam int OFF_W  = $clog2(BURST_BYTES);
  localparam int BEAT_W = (BW > 1) ? $clog2(BW) : 1;

  bdma_st_e          st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [31:0]       left_q, left_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              dir_q, dir_d, irqen_q, irqen_d;
  logic              done_q, done_d, err_q, err_d, berr_q, berr_d;
  logic              aligned, room, beat_last, rsp_last, rsp_fire;

  assign aligned   = (cfg_base[OFF_W-1:0] == '0) && (cfg_size[OFF_W-1:0] == '0);
  assign beat_last = (beat_q == BEAT_W'(BW - 1));
  assign room      = dir_q ? (wr_count >= CNT_W'(BW))
                           : ((CNT_W'(DEPTH) - rd_count) >= CNT_W'(BW));
  assign rsp_fire  = (st_q == ST_RSP) && rsp_val;
  assign rsp_last  = dir_q || beat_last;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    left_d  = left_q;
    beat_d  = beat_q;
    dir_d   = dir_q;
    irqen_d = irqen_q;
    done_d  = done_q;
    err_d   = err_q;
    berr_d  = berr_q;
    flush   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cfg_run) begin
          flush   = 1'b1;
          dir_d   = cfg_dir;
          irqen_d = cfg_irq_en;
          addr_d  = cfg_base;
          left_d  = cfg_size >> OFF_W;
          beat_d  = '0;
          if (!aligned) begin
            err_d = 1'b1;
            st_d  = ST_END;
          end else if (cfg_size == '0) begin
            done_d = 1'b1;
            st_d   = ST_END;
          end else begin
            st_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (room) begin
          beat_d = '0;
          st_d   = ST_CMD;
        end
      end
      ST_CMD: begin
        if (cmd_ack) begin
          if (beat_last) begin
            beat_d = '0;
            berr_d = 1'b0;
            st_d   = ST_RSP;
          end else begin
            beat_d = beat_q + BEAT_W'(1);
          end
        end
      end
      ST_RSP: begin
        if (rsp_val) begin
          berr_d = berr_q | rsp_err;
          if (!rsp_last) begin
            beat_d = beat_q + BEAT_W'(1);
          end else if (berr_q || rsp_err) begin
            err_d = 1'b1;
            st_d  = ST_END;
          end else if (left_q == 32'd1) begin
            done_d = 1'b1;
            st_d   = ST_END;
          end else begin
            addr_d = addr_q + ADDR_W'(BURST_BYTES);
            left_d = left_q - 32'd1;
            st_d   = ST_WAIT;
          end
        end
      end
      ST_END: begin
        if (!cfg_run) begin
          done_d = 1'b0;
          err_d  = 1'b0;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      beat_q  <= '0;
      dir_q   <= 1'b0;
      irqen_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      berr_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      beat_q  <= beat_d;
      dir_q   <= dir_d;
      irqen_q <= irqen_d;
      done_q  <= done_d;
      err_q   <= err_d;
      berr_q  <= berr_d;
    end
  end

  assign cmd_val  = (st_q == ST_CMD);
  assign cmd_addr = addr_q + ADDR_W'({beat_q, 2'b00});
  assign cmd_wr   = dir_q;
  assign cmd_eop  = cmd_val && beat_last;
  assign rsp_ack  = (st_q == ST_RSP);
  assign rd_push  = rsp_fire && !dir_q;
  assign wr_pop   = cmd_val && cmd_ack && dir_q;
  assign busy     = (st_q == ST_WAIT) || (st_q == ST_CMD) || (st_q == ST_RSP);
  assign done     = done_q;
  assign err      = err_q;
  assign irq      = done_q && irqen_q;
  assign dir      = dir_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_val && cmd_ack && !cmd_eop) |=> (cmd_val && cmd_addr == $past(cmd_addr) + ADDR_W'(4))); // R2
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_val && !cmd_ack) |=> (cmd_val && $stable(cmd_addr))); // R2
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !cmd_val); // R8
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && err_q)); // R8
  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(rsp_fire) || $past(st_q == ST_IDLE))); // R7
endmodule

// File: rtl/bdma_chan.sv
module bdma_chan #(
  parameter int ADDR_W      = 40,
  parameter int BURST_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_base_lo,
  input  logic [ADDR_W-33:0] cfg_base_hi,
  input  logic [31:0]       cfg_size,
  input  logic              cfg_dir,
  input  logic              cfg_irq_en,
  input  logic              cfg_run,
  output logic              stat_busy,
  output logic              stat_done,
  output logic              stat_err,
  output logic              irq,
  output logic              cmd_val,
  input  logic              cmd_ack,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_wr,
  output logic [31:0]       cmd_wdata,
  output logic              cmd_eop,
  input  logic              rsp_val,
  output logic              rsp_ack,
  input  logic [31:0]       rsp_rdata,
  input  logic              rsp_err,
  output logic              tc_val,
  input  logic              tc_rdy,
  output logic [31:0]       tc_data,
  input  logic              fc_val,
  output logic              fc_rdy,
  input  logic [31:0]       fc_data
);
  localparam int DEPTH = 2 * (BURST_BYTES / 4);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             rst_s_n;
  logic [CNT_W-1:0] rd_count, wr_count;
  logic             flush, rd_push, wr_pop, dir, busy;

  bdma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  bdma_ctrl #(
    .ADDR_W      (ADDR_W),
    .BURST_BYTES (BURST_BYTES),
    .DEPTH       (DEPTH)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .cfg_base   ({cfg_base_hi, cfg_base_lo}),
    .cfg_size   (cfg_size),
    .cfg_dir    (cfg_dir),
    .cfg_irq_en (cfg_irq_en),
    .cfg_run    (cfg_run),
    .rd_count   (rd_count),
    .wr_count   (wr_count),
    .cmd_val    (cmd_val),
    .cmd_ack    (cmd_ack),
    .cmd_addr   (cmd_addr),
    .cmd_wr     (cmd_wr),
    .cmd_eop    (cmd_eop),
    .rsp_val    (rsp_val),
    .rsp_ack    (rsp_ack),
    .rsp_err    (rsp_err),
    .flush      (flush),
    .rd_push    (rd_push),
    .wr_pop     (wr_pop),
    .busy       (busy),
    .done       (stat_done),
    .err        (stat_err),
    .irq        (irq),
    .dir        (dir)
  );

  bdma_fifo #(.W(32), .DEPTH(DEPTH)) u_rd_fifo (
    .clk   (clk),
    .rst_n (rst_s_n),
    .flush (flush),
    .push  (rd_push),
    .din   (rsp_rdata),
    .pop   (tc_val && tc_rdy),
    .dout  (tc_data),
    .count (rd_count)
  );

  bdma_fifo #(.W(32), .DEPTH(DEPTH)) u_wr_fifo (
    .clk   (clk),
    .rst_n (rst_s_n),
    .flush (flush),
    .push  (fc_val && fc_rdy),
    .din   (fc_data),
    .pop   (wr_pop),
    .dout  (cmd_wdata),
    .count (wr_count)
  );

  assign stat_busy = busy;
  assign tc_val    = (rd_count != '0);
  assign fc_rdy    = busy && dir && (wr_count != CNT_W'(DEPTH));
endmodule

// File: tb/bdma_chan_bench.sv
module bdma_chan_bench;
  localparam int AW = 40;
  localparam int BB = 16;
  localparam int BW = BB / 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] cfg_base_lo, cfg_size;
  logic [AW-33:0] cfg_base_hi;
  logic cfg_dir, cfg_irq_en, cfg_run;
  logic stat_busy, stat_done, stat_err, irq;
  logic cmd_val, cmd_ack, cmd_wr, cmd_eop;
  logic [AW-1:0] cmd_addr;
  logic [31:0] cmd_wdata, rsp_rdata, tc_data, fc_data;
  logic rsp_val, rsp_ack, rsp_err, tc_val, tc_rdy, fc_val, fc_rdy;

  always #5 clk = ~clk;

  bdma_chan #(.ADDR_W(AW), .BURST_BYTES(BB)) u_bdma_chan (.*);

  int total = 0, bad = 0;
  logic [31:0] src [256];
  logic [AW-1:0] exp_base, burst_base;
  logic exp_dir;
  int flit_cnt, addr_bad, eop_bad, dir_bad, wdata_bad, rx_cnt, rx_bad;
  int pend, rsp_beat, burst_cnt, err_at, fc_idx, fc_limit;
  bit tc_hold;

  function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
    return (a[31:0] * 32'h9E3779B1) ^ 32'hC3A50000 ^ {24'h0, a[39:32]};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory and coprocessor models, driven at falling edges
  initial begin
    cmd_ack = 0; rsp_val = 0; rsp_err = 0; rsp_rdata = 0;
    tc_rdy = 0; fc_val = 0; fc_data = 0;
    pend = 0; flit_cnt = 0; rx_cnt = 0; fc_idx = 0; fc_limit = 0;
    burst_cnt = 0; rsp_beat = 0; err_at = -1; tc_hold = 0;
    addr_bad = 0; eop_bad = 0; dir_bad = 0; wdata_bad = 0; rx_bad = 0;
    exp_base = '0; exp_dir = 0; burst_base = '0;
    forever begin
      @(negedge clk);
      if (pend > 0) begin
        rsp_val   = ($urandom % 4) != 0;
        rsp_rdata = mem_word(burst_base + AW'(4 * rsp_beat));
        rsp_err   = (burst_cnt == err_at);
      end else begin
        rsp_val = 0;
        rsp_err = 0;
      end
      cmd_ack = ($urandom % 4) != 0;
      tc_rdy  = tc_hold ? 1'b0 : (($urandom % 4) != 0);
      fc_val  = (fc_idx < fc_limit) && (($urandom % 4) != 0);
      fc_data = src[fc_idx % 256];
      #1;
      if (rsp_val && rsp_ack) begin
        pend--;
        rsp_beat++;
        if (pend == 0) burst_cnt++;
      end
      if (cmd_val && cmd_ack) begin
        if (flit_cnt % BW == 0) burst_base = cmd_addr;
        if (cmd_addr !== exp_base + AW'(4 * flit_cnt)) addr_bad++;
        if (cmd_eop !== (flit_cnt % BW == BW - 1)) eop_bad++;
        if (cmd_wr !== exp_dir) dir_bad++;
        if (cmd_wr && cmd_wdata !== src[flit_cnt % 256]) wdata_bad++;
        flit_cnt++;
        if (cmd_eop) begin
          pend = cmd_wr ? 1 : BW;
          rsp_beat = 0;
        end
      end
      if (tc_val && tc_rdy) begin
        if (tc_data !== mem_word(exp_base + AW'(4 * rx_cnt))) rx_bad++;
        rx_cnt++;
      end
      if (fc_val && fc_rdy) fc_idx++;
    end
  end

  task automatic prep(input logic [AW-1:0] base, input logic [31:0] size, input bit dir,
                      input bit irqen, input int errb);
    for (int i = 0; i < 200 && tc_val; i++) @(negedge clk);
    @(negedge clk);
    #2;
    flit_cnt = 0; rx_cnt = 0; rx_bad = 0; addr_bad = 0; eop_bad = 0; dir_bad = 0;
    wdata_bad = 0; burst_cnt = 0; fc_idx = 0; err_at = errb;
    for (int i = 0; i < 256; i++) src[i] = $urandom;
    fc_limit = dir ? int'(size / 4) : 0;
    exp_base = base; exp_dir = dir;
    cfg_base_lo = base[31:0]; cfg_base_hi = base[AW-1:32];
    cfg_size = size; cfg_dir = dir; cfg_irq_en = irqen; cfg_run = 1;
  endtask

  task automatic finish_xfer(input int nb, input bit irqen, input bit exp_err,
                             input int exp_flits, input string tag);
    int words;
    words = nb * BW;
    for (int i = 0; i < 5000 && !(stat_done || stat_err); i++) @(negedge clk);
    if (!exp_dir && !exp_err)
      for (int i = 0; i < 500 && rx_cnt < words; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(stat_done == !exp_err, {tag, " R7 done"}, stat_done, !exp_err);
    chk(stat_err == exp_err, {tag, " R8 err"}, stat_err, exp_err);
    chk(irq == (irqen && !exp_err), {tag, " R7 irq"}, irq, irqen && !exp_err);
    chk(!stat_busy, {tag, " R7 busy"}, stat_busy, 0);
    chk(flit_cnt == exp_flits, {tag, " R2 flits"}, flit_cnt, exp_flits);
    chk(addr_bad == 0 && eop_bad == 0, {tag, " R2 addr/eop"}, addr_bad + eop_bad, 0);
    chk(dir_bad == 0, {tag, " R3 R4 dir"}, dir_bad, 0);
    if (!exp_err && exp_dir) chk(wdata_bad == 0, {tag, " R4 wdata"}, wdata_bad, 0);
    if (!exp_err && !exp_dir)
      chk(rx_cnt == words && rx_bad == 0, {tag, " R3 rx"}, rx_cnt * 1000 + rx_bad, words * 1000);
    cfg_run = 0;
    repeat (2) @(negedge clk);
    chk(!stat_done && !stat_err && !irq, {tag, " R7 clear"}, {stat_done, stat_err, irq}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1BAD5EED));
    rst_n = 0; cfg_base_lo = 0; cfg_base_hi = 0; cfg_size = 0;
    cfg_dir = 0; cfg_irq_en = 0; cfg_run = 0;
    repeat (4) @(negedge clk);
    chk({stat_busy, stat_done, stat_err, irq, cmd_val, rsp_ack, tc_val, fc_rdy} == 0,
        "R1 in reset", {stat_busy, stat_done, stat_err, irq, cmd_val, rsp_ack, tc_val, fc_rdy}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk({stat_busy, stat_done, stat_err, irq, cmd_val, rsp_ack, tc_val, fc_rdy} == 0,
        "R1 after reset", {stat_busy, stat_done, stat_err, irq, cmd_val, rsp_ack, tc_val, fc_rdy}, 0);

    // R3 read, interrupt mode
    prep(40'h00_0000_1000, 3 * BB, 0, 1, -1);
    finish_xfer(3, 1, 0, 3 * BW, "read3");
    // R4 write, no interrupt
    prep(40'h00_0000_2040, 2 * BB, 1, 0, -1);
    finish_xfer(2, 0, 0, 2 * BW, "write2");
    // R2 carry from low word into high word
    prep(40'h03_FFFF_FFF0, 2 * BB, 0, 0, -1);
    finish_xfer(2, 0, 0, 2 * BW, "carry R2");

    // R5 stalled coprocessor: only two read bursts fit
    tc_hold = 1;
    prep(40'h00_0000_4000, 4 * BB, 0, 1, -1);
    repeat (200) @(negedge clk);
    chk(flit_cnt == 2 * BW, "R5 stalled flits", flit_cnt, 2 * BW);
    chk(stat_busy, "R5 still busy", stat_busy, 1);
    tc_hold = 0;
    finish_xfer(4, 1, 0, 4 * BW, "stall R5");

    // R6 one word short of a burst
    prep(40'h00_0000_5000, BB, 1, 1, -1);
    fc_limit = BW - 1;
    repeat (60) @(negedge clk);
    chk(flit_cnt == 0, "R6 partial burst held", flit_cnt, 0);
    fc_limit = BW;
    finish_xfer(1, 1, 0, BW, "partial R6");

    // R8 error responses
    prep(40'h00_0000_6000, 4 * BB, 0, 1, 1);
    finish_xfer(4, 1, 1, 2 * BW, "rd err R8");
    prep(40'h00_0000_7000, 3 * BB, 1, 1, 0);
    finish_xfer(3, 1, 1, BW, "wr err R8");

    // R9 misaligned base and size
    prep(40'h00_0000_1004, 2 * BB, 0, 1, -1);
    finish_xfer(2, 1, 1, 0, "bad base R9");
    prep(40'h00_0000_1000, BB + 4, 1, 1, -1);
    finish_xfer(1, 1, 1, 0, "bad size R9");

    // R10 zero size
    prep(40'h00_0000_8000, 0, 0, 1, -1);
    finish_xfer(0, 1, 0, 0, "zero R10");
    prep(40'h00_0000_8000, 0, 1, 0, -1);
    finish_xfer(0, 0, 0, 0, "zero noirq R10");

    // random transfers
    for (int t = 0; t < 12; t++) begin
      logic [AW-1:0] b;
      int nb;
      bit d, ie;
      b  = {8'($urandom), $urandom & 32'hFFFF_FFF0};
      nb = 1 + ($urandom % 6);
      d  = $urandom % 2;
      ie = $urandom % 2;
      prep(b, 32'(nb * BB), d, ie, -1);
      finish_xfer(nb, ie, 0, nb * BW, "random R2 R3 R4");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule